// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block is the timing core of a PWM generator. A 16-bit counter advances on ticks from a two-stage clock prescaler. It can count upward, downward or up-down, or it can hold its value. Downstream compare and action logic receives the current count together with two single-cycle events. One event marks a zero match and the other marks a match with the active period. Software programs the block through two 16-bit registers on a small word-addressed write port, and can read each register back.

The period value is written in one of two ways. It goes either straight into the active register, or into a shadow copy that is committed only at a counter zero, so a new period never cuts a running cycle short. A two-bit run field selects how the counter stops: it halts at once, it halts once the running cycle reaches zero, or it runs without limit. One period register serves every compare channel built on this counter.

Top module: `pwm_timebase`

## Requirements
- R1: While rst_ni is low and after it is released, both registers read 0 and count_o is 0.
- R2: A tick occurs every H*C clock cycles, and the counter changes only on ticks. H is taken from control bits [9:7] (field value 0 gives H=1, and a value n from 1 to 7 gives H=2n). C is 2 to the power of control bits [12:10].
- R3: Mode 00 (control bits [1:0]) counts up by one per tick and goes from the active period to 0. The counter runs through period+1 values per cycle.
- R4: Mode 01 counts down by one per tick and reloads the active period when it is at 0.
- R5: Mode 10 counts up to the active period, then down to 0, then up again. With period P a full cycle lasts 2P ticks.
- R6: Mode 11 holds the counter at its current value.
- R7: Run field 00 (control bits [15:14]) holds the counter from the first tick after the write. A run field of 10 or 11 lets the counter advance freely.
- R8: Run field 01 lets the counter advance while it is non-zero and holds it once it reaches 0.
- R9: With control bit 3 set, a period write updates the active period at once.
- R10: With control bit 3 clear, a period write goes to the shadow register. The active period takes the shadow value on the next tick at which the count is 0.
- R11: zero_evt_o is high for the cycle of a tick at which the count is 0. prd_evt_o is high for the cycle of a tick at which the count equals the active period.
- R12: Address 0 selects the control register and address 1 selects the period. rdata_o is combinational on addr_i and returns the control value or the active period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Word address: 0 control, 1 period |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| count_o | output | 16 | Current counter value |
| zero_evt_o | output | 1 | Tick with count equal to 0 |
| prd_evt_o | output | 1 | Tick with count equal to active period |

## Verification
The hardest situation to reach is a shadowed period write that lands in the middle of a running cycle, followed by its commit at the next zero. The stimulus first starts an up-count with a long period and lets it advance a known number of ticks. It then writes a shorter period. The read-back must still return the old period until the count wraps, and the new wrap point must apply from the following cycle. The prescaler is swept over all 64 divider combinations, and the bench measures the spacing between zero events against the product formula.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;
  typedef enum logic [1:0] {
    CNT_UP     = 2'b00,
    CNT_DOWN   = 2'b01,
    CNT_UPDOWN = 2'b10,
    CNT_FROZEN = 2'b11
  } cnt_mode_e;

  localparam int MODE_LSB   = 0;
  localparam int DIRECT_BIT = 3;
  localparam int HS_LSB     = 7;
  localparam int CD_LSB     = 10;
  localparam int RUN_LSB    = 14;
endpackage

// File: rtl/pwm_timebase_prescale.sv
module pwm_timebase_prescale #(
  parameter int HS_W = 3,
  parameter int CD_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [HS_W-1:0] hs_sel_i,
  input  logic [CD_W-1:0] cd_sel_i,
  output logic            tick_o
);
  localparam int HSL = HS_W + 1;
  localparam int CDL = 1 << CD_W;

  logic [HSL-1:0] hs_cnt_q, hs_lim;
  logic [CDL-1:0] cd_cnt_q, cd_lim;
  logic [CDL:0]   cd_pow;
  logic           hs_tick, cd_wrap;

  always_comb begin
    hs_lim  = (hs_sel_i == '0) ? '0 : ({hs_sel_i, 1'b0} - HSL'(1));
    cd_pow  = (CDL+1)'(1) << cd_sel_i;
    cd_lim  = cd_pow[CDL-1:0] - CDL'(1);
    hs_tick = (hs_cnt_q >= hs_lim);
    cd_wrap = (cd_cnt_q >= cd_lim);
    tick_o  = hs_tick && cd_wrap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_cnt_q <= '0;
      cd_cnt_q <= '0;
    end else begin
      hs_cnt_q <= hs_tick ? '0 : hs_cnt_q + HSL'(1);
      if (hs_tick) cd_cnt_q <= cd_wrap ? '0 : cd_cnt_q + CDL'(1);
    end
  end

  // divide ratio above 1: ticks never on back-to-back cycles unless config moves
  assert_tick_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && (hs_lim != '0 || cd_lim != '0)) |=>
      (!tick_o || !$stable(hs_sel_i) || !$stable(cd_sel_i)));
endmodule

// File: rtl/pwm_timebase_regs.sv
module pwm_timebase_regs #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          commit_i,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] prd_o,
  output logic [DW-1:0] rdata_o
);
  import pwm_timebase_pkg::*;

  logic [DW-1:0] ctrl_q, shadow_q, prd_q;
  logic          wr_ctrl, wr_prd, direct;

  assign wr_ctrl = wr_en_i && !addr_i;
  assign wr_prd  = wr_en_i && addr_i;
  assign direct  = ctrl_q[DIRECT_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      shadow_q <= '0;
      prd_q    <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i;
      if (wr_prd) shadow_q <= wdata_i;
      if (wr_prd && direct) prd_q <= wdata_i;
      else if (commit_i)    prd_q <= shadow_q;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign prd_o   = prd_q;
  assign rdata_o = addr_i ? prd_q : ctrl_q;

  assert_direct_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_prd && direct) |=> (prd_o == $past(wdata_i)));

  assert_prd_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_prd && direct) && !commit_i) |=> $stable(prd_o));
endmodule

// File: rtl/pwm_timebase_counter.sv
module pwm_timebase_counter #(
  parameter int DW = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         tick_i,
  input  pwm_timebase_pkg::cnt_mode_e  mode_i,
  input  logic [1:0]                   run_i,
  input  logic [DW-1:0]                prd_i,
  output logic [DW-1:0]                count_o,
  output logic                         zero_evt_o,
  output logic                         prd_evt_o
);
  import pwm_timebase_pkg::*;

  logic [DW-1:0] cnt_q, cnt_d;
  logic          dir_up_q, dir_up_d;
  logic          hold;

  assign hold = (mode_i == CNT_FROZEN) || (run_i == 2'b00) ||
                (run_i == 2'b01 && cnt_q == '0);

  always_comb begin
    cnt_d    = cnt_q;
    dir_up_d = dir_up_q;
    if (tick_i && !hold) begin
      unique case (mode_i)
        CNT_UP:   cnt_d = (cnt_q >= prd_i) ? '0 : cnt_q + DW'(1);
        CNT_DOWN: cnt_d = (cnt_q == '0 || cnt_q > prd_i) ? prd_i : cnt_q - DW'(1);
        CNT_UPDOWN: begin
          if (dir_up_q) begin
            if (cnt_q >= prd_i) begin
              dir_up_d = 1'b0;
              cnt_d    = (cnt_q == '0) ? '0 : cnt_q - DW'(1);
            end else begin
              cnt_d = cnt_q + DW'(1);
            end
          end else if (cnt_q == '0) begin
            dir_up_d = 1'b1;
            cnt_d    = (prd_i == '0) ? '0 : DW'(1);
          end else begin
            cnt_d = cnt_q - DW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      dir_up_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_d;
      dir_up_q <= dir_up_d;
    end
  end

  assign count_o    = cnt_q;
  assign zero_evt_o = tick_i && (cnt_q == '0);
  assign prd_evt_o  = tick_i && (cnt_q == prd_i);

  assert_idle_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_o));

  assert_run_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_i == 2'b00) |=> $stable(count_o));

  assert_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == CNT_FROZEN) |=> $stable(count_o));

  assert_up_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_i[1] && mode_i == CNT_UP && count_o == prd_i) |=> (count_o == '0));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int DW   = 16,
  parameter int HS_W = 3,
  parameter int CD_W = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] count_o,
  output logic          zero_evt_o,
  output logic          prd_evt_o
);
  import pwm_timebase_pkg::*;

  logic [DW-1:0] ctrl, prd;
  logic          tick, zero_evt;

  pwm_timebase_regs #(.DW(DW)) regs_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .commit_i (zero_evt),
    .ctrl_o   (ctrl),
    .prd_o    (prd),
    .rdata_o  (rdata_o)
  );

  pwm_timebase_prescale #(.HS_W(HS_W), .CD_W(CD_W)) presc_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hs_sel_i (ctrl[HS_LSB +: HS_W]),
    .cd_sel_i (ctrl[CD_LSB +: CD_W]),
    .tick_o   (tick)
  );

  pwm_timebase_counter #(.DW(DW)) cnt_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .mode_i     (cnt_mode_e'(ctrl[MODE_LSB +: 2])),
    .run_i      (ctrl[RUN_LSB +: 2]),
    .prd_i      (prd),
    .count_o    (count_o),
    .zero_evt_o (zero_evt),
    .prd_evt_o  (prd_evt_o)
  );

  assign zero_evt_o = zero_evt;
endmodule

// File: tb/pwm_timebase_tb_top.sv
`timescale 1ns/1ps
module pwm_timebase_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        addr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, count;
  logic        zero_evt, prd_evt;
  int          checks = 0;
  int          failures = 0;
  int          cycles = 0;

  always #4 clk = ~clk;

  pwm_timebase dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .count_o(count),
    .zero_evt_o(zero_evt), .prd_evt_o(prd_evt)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int c;
    // R1 reset state
    #1;
    addr = 1'b0; #1;
    chk(rdata == 16'h0, "R1 ctrl", rdata, 0);
    addr = 1'b1; #1;
    chk(rdata == 16'h0, "R1 period", rdata, 0);
    chk(count == 16'h0, "R1 count", count, 0);
    @(negedge clk); rst_n = 1'b1;
    step(3);
    chk(count == 16'h0, "R1 count after release", count, 0);

    // R2 prescaler sweep: period 0, up mode, zero event every tick
    wr(1'b0, 16'h0008);
    wr(1'b1, 16'h0000);
    for (int cd = 0; cd < 8; cd++) begin
      for (int hs = 0; hs < 8; hs++) begin
        int n, exp_div, guard;
        wr(1'b0, 16'hC008 | 16'(cd << 10) | 16'(hs << 7));
        guard = 0;
        while (!zero_evt && guard < 4000) begin step(1); guard++; end
        n = 0;
        do begin step(1); n++; end while (!zero_evt && n < 4000);
        exp_div = ((hs == 0) ? 1 : 2 * hs) * (1 << cd);
        chk(n == exp_div, "R2 tick spacing", n, exp_div);
      end
    end

    // R3 up mode + R11 events, period 5
    do_reset();
    wr(1'b0, 16'h0008);
    wr(1'b1, 16'd5);
    addr = 1'b1; #1;
    chk(rdata == 16'd5, "R9 direct load readback", rdata, 5);
    wr(1'b0, 16'hC008);
    addr = 1'b0; #1;
    chk(rdata == 16'hC008, "R12 ctrl readback", rdata, 16'hC008);
    for (int k = 1; k <= 14; k++) begin
      int e;
      step(1);
      e = k % 6;
      chk(count == 16'(e), "R3 up count", count, e);
      chk(zero_evt == (e == 0), "R11 zero event", zero_evt, e == 0);
      chk(prd_evt == (e == 5), "R11 period event", prd_evt, e == 5);
    end

    // R7 run 00 holds from next tick
    wr(1'b0, 16'h0008);
    c = count;
    step(6);
    chk(count == 16'(c), "R7 run stop hold", count, c);

    // R4 down mode
    do_reset();
    wr(1'b0, 16'h0009);
    wr(1'b1, 16'd5);
    wr(1'b0, 16'hC009);
    for (int k = 1; k <= 13; k++) begin
      int e;
      step(1);
      e = 5 - ((k - 1) % 6);
      chk(count == 16'(e), "R4 down count", count, e);
    end

    // R6 freeze mode with run free
    wr(1'b0, 16'hC00B);
    c = count;
    step(7);
    chk(count == 16'(c), "R6 freeze", count, c);

    // R5 up-down, period 4
    do_reset();
    wr(1'b0, 16'h000A);
    wr(1'b1, 16'd4);
    wr(1'b0, 16'hC00A);
    for (int k = 1; k <= 17; k++) begin
      int m, e;
      step(1);
      m = k % 8;
      e = (m <= 4) ? m : 8 - m;
      chk(count == 16'(e), "R5 up-down count", count, e);
    end

    // R8 stop at end of cycle
    do_reset();
    wr(1'b0, 16'h0008);
    wr(1'b1, 16'd5);
    wr(1'b0, 16'hC008);
    step(2);
    wr(1'b0, 16'h4008);
    chk(count == 16'd3, "R8 at write", count, 3);
    step(1);
    chk(count == 16'd4, "R8 still advancing", count, 4);
    step(6);
    chk(count == 16'd0, "R8 stopped at zero", count, 0);
    step(4);
    chk(count == 16'd0, "R8 holds zero", count, 0);

    // R10 shadow load committed at zero
    do_reset();
    wr(1'b0, 16'h0008);
    wr(1'b1, 16'd5);
    wr(1'b0, 16'hC000);
    step(2);
    wr(1'b1, 16'd2);
    addr = 1'b1; #1;
    chk(rdata == 16'd5, "R10 active unchanged after write", rdata, 5);
    chk(count == 16'd3, "R10 count at write", count, 3);
    step(3);
    chk(count == 16'd0 && rdata == 16'd5, "R10 before commit", rdata, 5);
    step(1);
    chk(rdata == 16'd2, "R10 committed", rdata, 2);
    chk(count == 16'd1, "R10 count after commit", count, 1);
    step(1);
    chk(prd_evt == 1'b1, "R11 period event new period", prd_evt, 1);
    step(1);
    chk(count == 16'd0, "R10 wraps at new period", count, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule